// File: doc/BRIEF.md
# ECC-Inserting Write Burst Serializer

This block turns one wide local-side write word into a burst of narrow beats for an external memory data path. The local word is cut into 64-bit slices. Slice 0 (the least significant) goes out first and the most significant slice goes out last. Each beat carries its slice in bits 63:0. When error correction is enabled, an 8-bit single-error-correct, double-error-detect check byte for that slice sits above it, in bits 71:64.

The parameter `QUARTER_RATE` sets the burst length. When it is 0 (half-rate), a 256-bit word gives 4 beats. When it is 1 (quarter-rate), a 512-bit word gives an 8-beat burst. The parameter `ECC_EN` sets the beat width: 72 bits with the check byte, or 64 bits with the check logic removed.

Both sides use valid/ready handshakes. The block stores one word. It accepts the next word in the same cycle that the last beat of the current burst is taken, so bursts can run back to back with no idle beat between them.

Top module: `ecc_burst_ser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready_o` is 1 and `beat_valid_o` is 0.
- R2: Each accepted word produces exactly 4 beats (QUARTER_RATE=0) or 8 beats (QUARTER_RATE=1). `beat_last_o` is 1 on the final beat and 0 on every other beat.
- R3: Beat k of a burst carries bits [64k+63:64k] of the accepted word in `beat_data_o[63:0]`.
- R4: With ECC_EN=1, `beat_data_o[71:64]` is the check byte of that beat's slice d. For d, data bit i is assigned to the i-th position p in 1..71 that is not a power of two. Bits [6:0] are the XOR of the position numbers p of all set data bits. Bit 7 is the XOR of all 64 data bits and bits [6:0]. For example, d=1 gives 8'h83 and d=0 gives 8'h00.
- R5: `in_ready_o` is 1 when no burst is pending. It is also 1 in the cycle where the last beat is handshaken, and 0 otherwise. After an accepted word, `beat_valid_o` is 1 in the next cycle.
- R6: While `beat_valid_o` is 1 and `beat_ready_i` is 0, `beat_valid_o`, `beat_data_o` and `beat_last_o` hold their values into the next cycle. The beat position moves only on a handshake.
- R7: With ECC_EN=0, the beat is 64 bits wide and holds only the slice.
- R8: `in_data_i` and `in_valid_i` are ignored while `in_ready_o` is 0. A burst in progress keeps emitting the word that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Local word valid |
| in_ready_o | output | 1 | Local word can be taken this cycle |
| in_data_i | input | WORD_W (512 or 256) | Local write word |
| beat_valid_o | output | 1 | Beat valid |
| beat_ready_i | input | 1 | Beat taken by the external side |
| beat_data_o | output | BEAT_W (72 or 64) | Beat: check byte over data slice |
| beat_last_o | output | 1 | Final beat of the burst |

## Verification
Two events can fall in the same cycle: the handshake of a burst's last beat and the acceptance of the next local word. In that cycle, ready must rise on the input side and the beat position must restart at slice 0 with the new word. The bench provokes this with runs of continuous beat ready and always-valid input. It also uses random mixes of input valid and beat ready. A reference model predicts, cycle by cycle, when input ready should be high and which slice and check byte must appear next. The bench compares that prediction with the ports of a quarter-rate instance with the check byte and a half-rate instance without it.

// File: rtl/ecc_ser_pkg.sv
package ecc_ser_pkg;
  localparam int unsigned SLICE_W = 64;
  localparam int unsigned HAM_W   = 7;
  localparam int unsigned CHK_W   = HAM_W + 1;
  localparam int unsigned CODE_N  = SLICE_W + HAM_W;

  typedef logic [SLICE_W-1:0] slice_t;
  typedef logic [CHK_W-1:0]   chk_t;

  // Data bits covered by Hamming bit j; data occupies non power-of-two positions 1..71
  function automatic slice_t ham_mask(input int unsigned bit_j);
    slice_t      m;
    int unsigned di;
    m  = '0;
    di = 0;
    for (int unsigned p = 1; p <= CODE_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        m[di[5:0]] = ((p >> bit_j) & 1) != 0;
        di++;
      end
    end
    return m;
  endfunction

  function automatic int unsigned beats_for(input bit quarter);
    return quarter ? 8 : 4;
  endfunction
endpackage

// File: rtl/ecc_ser_secded.sv
module ecc_ser_secded
  import ecc_ser_pkg::*;
(
  input  slice_t data_i,
  output chk_t   chk_o
);
  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_ham
    localparam slice_t MASK = ham_mask(j);
    assign ham[j] = ^(data_i & MASK);
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/ecc_ser_seq.sv
module ecc_ser_seq #(
  parameter int unsigned BEATS = 8,
  localparam int unsigned CNT_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             beat_ready_i,
  output logic             beat_valid_o,
  output logic             beat_last_o,
  output logic [CNT_W-1:0] beat_idx_o,
  output logic             load_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hs;

  assign beat_valid_o = busy_q;
  assign beat_idx_o   = cnt_q;
  assign beat_last_o  = busy_q && (cnt_q == CNT_W'(BEATS - 1));
  assign hs           = busy_q && beat_ready_i;
  // next word may enter as the last beat leaves
  assign in_ready_o   = !busy_q || (hs && beat_last_o);
  assign load_o       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hs) begin
      if (beat_last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_burst_ser.sv
module ecc_burst_ser
  import ecc_ser_pkg::*;
#(
  parameter bit QUARTER_RATE = 1'b1,
  parameter bit ECC_EN       = 1'b1,
  localparam int unsigned BEATS  = beats_for(QUARTER_RATE),
  localparam int unsigned WORD_W = SLICE_W * BEATS,
  localparam int unsigned BEAT_W = ECC_EN ? SLICE_W + CHK_W : SLICE_W,
  localparam int unsigned CNT_W  = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [BEAT_W-1:0] beat_data_o,
  output logic              beat_last_o
);
  logic              load;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  slice_t            slices [BEATS];
  slice_t            cur;

  ecc_ser_seq #(.BEATS(BEATS)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .beat_ready_i (beat_ready_i),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .beat_idx_o   (idx),
    .load_o       (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (load) word_q <= in_data_i;
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_slice
    assign slices[b] = word_q[b*SLICE_W +: SLICE_W];
  end
  assign cur = slices[idx];

  if (ECC_EN) begin : g_ecc
    chk_t chk;
    ecc_ser_secded i_enc (.data_i(cur), .chk_o(chk));
    assign beat_data_o = {chk, cur};
  end else begin : g_raw
    assign beat_data_o = cur;
  end
endmodule

// File: rtl/ecc_burst_ser_chk.sv
module ecc_burst_ser_chk #(
  parameter int unsigned BEATS  = 8,
  parameter int unsigned BEAT_W = 72,
  parameter bit          ECC_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [BEAT_W-1:0] beat_data_o,
  input logic              beat_last_o
);
  logic [7:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) n_q <= '0;
    else if (beat_valid_o && beat_ready_i) n_q <= beat_last_o ? 8'd0 : n_q + 8'd1;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o) && $stable(beat_last_o));

  p_idle_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> in_ready_o);

  p_busy_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !(beat_ready_i && beat_last_o) |-> !in_ready_o);

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> beat_valid_o);

  p_last_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_last_o |-> n_q == 8'(BEATS - 1));

  if (ECC_EN) begin : g_par
    p_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      beat_valid_o |-> (^beat_data_o) == 1'b0);
  end
endmodule

bind ecc_burst_ser ecc_burst_ser_chk #(.BEATS(BEATS), .BEAT_W(BEAT_W), .ECC_EN(ECC_EN)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_data_o  (beat_data_o),
  .beat_last_o  (beat_last_o)
);

// File: tb/test_ecc_burst_ser.sv
`timescale 1ns/1ps
module test_ecc_burst_ser;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         beat_ready = 1'b0;
  logic [511:0] in_data = '0;

  logic        q_in_ready, q_valid, q_last;
  logic [71:0] q_data;
  logic        h_in_ready, h_valid, h_last;
  logic [63:0] h_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [511:0] expq [2][$];
  int           bidx [2];
  bit           st_p [2];
  logic [71:0]  st_d [2];
  bit           st_l [2];

  always #2.5 clk = ~clk;

  ecc_burst_ser #(.QUARTER_RATE(1'b1), .ECC_EN(1'b1)) i_ecc_burst_ser (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(q_in_ready),
    .in_data_i(in_data), .beat_valid_o(q_valid), .beat_ready_i(beat_ready),
    .beat_data_o(q_data), .beat_last_o(q_last));

  ecc_burst_ser #(.QUARTER_RATE(1'b0), .ECC_EN(1'b0)) i_ecc_burst_ser_half (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(h_in_ready),
    .in_data_i(in_data[255:0]), .beat_valid_o(h_valid), .beat_ready_i(beat_ready),
    .beat_data_o(h_data), .beat_last_o(h_last));

  // check byte: XOR of code positions of set data bits, then overall parity
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] s;
    int         i;
    s = '0;
    i = 0;
    for (int p = 1; p <= 71; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        if (d[i]) s ^= 7'(p);
        i++;
      end
    end
    return {(^d) ^ (^s), s};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mon(input int u);
    bit          v, r, l, ev, er;
    logic [71:0] d, ed;
    logic [63:0] sl;
    int          nb;
    v  = (u == 0) ? q_valid : h_valid;
    r  = (u == 0) ? q_in_ready : h_in_ready;
    l  = (u == 0) ? q_last : h_last;
    d  = (u == 0) ? q_data : {8'h00, h_data};
    nb = (u == 0) ? 8 : 4;
    ev = expq[u].size() > 0;
    er = !ev || (expq[u].size() == 1 && beat_ready && bidx[u] == nb - 1);
    chk(v == ev, "R5 beat_valid", 72'(v), 72'(ev));
    chk(r == er, "R5 in_ready", 72'(r), 72'(er));
    if (st_p[u]) chk(d == st_d[u] && l == st_l[u], "R6 hold", d, st_d[u]);
    if (ev && v) begin
      sl = expq[u][0][64*bidx[u] +: 64];
      ed = (u == 0) ? {ref_chk(sl), sl} : {8'h00, sl};
      chk(d == ed, (u == 0) ? "R3/R4/R8 beat" : "R3/R7/R8 beat", d, ed);
      chk(l == (bidx[u] == nb - 1), "R2 last", 72'(l), 72'(bidx[u] == nb - 1));
      if (beat_ready) begin
        if (bidx[u] == nb - 1) begin
          void'(expq[u].pop_front());
          bidx[u] = 0;
        end else bidx[u]++;
      end
    end
    if (in_valid && r) expq[u].push_back((u == 0) ? in_data : {256'h0, in_data[255:0]});
    st_p[u] = v && !beat_ready;
    st_d[u] = d;
    st_l[u] = l;
  endtask

  task automatic cyc(input bit iv, input logic [511:0] dat, input bit br);
    @(negedge clk);
    in_valid   = iv;
    in_data    = dat;
    beat_ready = br;
    #1;
    mon(0);
    mon(1);
  endtask

  function automatic logic [511:0] rnd_word();
    logic [511:0] w;
    for (int k = 0; k < 16; k++) w[32*k +: 32] = $urandom();
    return w;
  endfunction

  initial begin
    void'($urandom(32'd20131010));
    for (int u = 0; u < 2; u++) begin
      bidx[u] = 0; st_p[u] = 1'b0; st_d[u] = '0; st_l[u] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(q_in_ready && h_in_ready, "R1 in_ready", 72'({q_in_ready, h_in_ready}), 72'h3);
    chk(!q_valid && !h_valid, "R1 beat_valid", 72'({q_valid, h_valid}), 72'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(q_in_ready && !q_valid, "R1 after release", 72'({q_in_ready, q_valid}), 72'h2);

    // back-to-back words, last beat and next accept coincide
    cyc(1'b1, '0, 1'b1);
    cyc(1'b1, '1, 1'b1);
    cyc(1'b1, 512'h1, 1'b1);
    for (int i = 0; i < 40; i++) cyc(1'b1, rnd_word(), 1'b1);
    // long stall with junk offered on the input
    for (int i = 0; i < 12; i++) cyc(1'b1, rnd_word(), 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b0, rnd_word(), 1'b1);
    // random mix
    for (int i = 0; i < 3000; i++)
      cyc(($urandom() % 3) != 0, rnd_word(), ($urandom() % 10) < 7);
    for (int i = 0; i < 30; i++) cyc(1'b0, '0, 1'b1);
    chk(expq[0].size() == 0 && expq[1].size() == 0, "R2 drained",
        72'(expq[0].size() + expq[1].size()), 72'h0);

    // known check byte for slice value 1
    cyc(1'b1, 512'h1, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(q_data[71:64] == 8'h83, "R4 known byte", 72'(q_data[71:64]), 72'h83);
    chk(h_data == 64'h1, "R7 narrow beat", 72'(h_data), 72'h1);
    for (int i = 0; i < 12; i++) cyc(1'b0, '0, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule